// File: doc/BRIEF.md
# Dual-Channel Transmit FIFO Controller

This block gives software two independent transmit byte queues that share one 32-bit data port. A select register chooses which queue receives the data words. Each queue has its own length register and its own start register. When a start is accepted, the block sends the requested bytes from that queue as a single frame on an 8-bit valid/ready byte stream, and it marks the final byte with a last flag. When the frame finishes, the queue is emptied and a per-channel completion status bit is set. The interrupt output is high whenever a status bit is set and its mask bit is also set.

Software uses a single write port and a combinational read port, both at word addresses. The addresses are:

| Address | Register |
|---|---|
| 0 | control: bit 0 soft reset, bit 1 transmit enable |
| 1 | mode, a 32-bit scratch value |
| 2 | channel select |
| 3 | data, write only |
| 4 | length of channel 0 |
| 5 | length of channel 1 |
| 6 | start of channel 0 |
| 7 | start of channel 1 |
| 8 | mask, bits 1:0 |
| 9 | status, bits 1:0 |

Any other address reads as zero. Each queue holds 2048 bytes. When a register write lands in the same cycle as the end of a frame, the register write takes effect after the end-of-frame updates.

Top module: `txq_dual`

## Requirements
- R1: After rst_n is low at a clock edge, every readable register reads 0, tx_valid is low and irq is low.
- R2: A write of 0 or 1 to the select register (address 2) stores that value. Any other value stores 0.
- R3: A write to the data register (address 3) appends the four bytes of wr_data to the selected queue, starting with bits 7:0. If fewer than 4 of the 2048 bytes are free, the whole word is dropped.
- R4: A length write (address 4 or 5) greater than 2048 stores 2048. Any other value is stored as written.
- R5: A start write (address 6 or 7) is accepted only when wr_data bit 0 is 1 and control bit 1 is 1.
- R6: An accepted start sends the smaller of the channel's length and the number of bytes in its queue. If that count is 0, nothing is sent and no status bit changes.
- R7: After the last byte of a frame is taken, that channel's queue is empty, its length reads 0, and its status bit is set: bit 0 for channel 0, bit 1 for channel 1.
- R8: Frame bytes are presented in queue order. While tx_ready is low, tx_valid, tx_data and tx_last hold their values. tx_last is high only on the final byte.
- R9: A start write is ignored while a frame from either channel is still being sent.
- R10: irq is high exactly when (status AND mask) is nonzero. Writing the status register (address 9) clears each bit that is written as 1.
- R11: A control write with bit 0 set clears mode, mask, status, select, both queues and both lengths, and aborts any frame in flight. The control register stores the written value with bit 0 forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | AW | Register read word address |
| rd_data | output | 32 | Register read data, combinational |
| tx_valid | output | 1 | A frame byte is presented |
| tx_ready | input | 1 | The sink takes the byte this cycle |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |
| irq | output | 1 | Masked completion interrupt |

## Verification
The hold property on the stream assumes that only a soft reset can withdraw a presented byte. The stimulus therefore issues soft resets only where a dropped frame is intended. The checks assume a single write per cycle on the register port. The bench drives each write for exactly one cycle and changes wr_data, tx_ready and rd_addr only on the falling clock edge, so every input is stable at the sampling edge. Backpressure comes from constant-high, constant-low and pseudo-random tx_ready patterns. One test fills a queue past its 2048-byte capacity to exercise the dropped-word case.

// File: rtl/txq_dual.sv
module txq_dual #(
  parameter int FIFO_BYTES = 2048,
  parameter int AW = 4
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic          irq
);
  localparam int WORDS = FIFO_BYTES / 4;
  localparam int WW = $clog2(WORDS);
  localparam int LW = $clog2(FIFO_BYTES + 1);
  localparam logic [LW-1:0] CAP = LW'(FIFO_BYTES);
  localparam logic [LW-1:0] ROOM = LW'(FIFO_BYTES - 4);
  localparam logic [AW-1:0] A_CTRL = AW'(0), A_MODE = AW'(1), A_SEL = AW'(2), A_DATA = AW'(3),
                            A_LEN0 = AW'(4), A_GO0 = AW'(6), A_MASK = AW'(8), A_STAT = AW'(9);

  logic [31:0]   ctrl_q, mode_q;
  logic          sel_q, busy_q, ch_q;
  logic [1:0]    mask_q, stat_q;
  logic [LW-1:0] idx_q, flen_q;
  logic [LW-1:0] lvl0, lvl1, len0, len1;
  logic [31:0]   word0, word1, cur_word;
  logic          go0, go1;
  logic [LW-1:0] fl0, fl1;

  wire soft_rst = wr_en && wr_addr == A_CTRL && wr_data[0];
  wire done     = tx_valid && tx_ready && tx_last;
  wire [LW-1:0] len_in = (wr_data > 32'(FIFO_BYTES)) ? CAP : wr_data[LW-1:0];

  for (genvar c = 0; c < 2; c++) begin : g_ch
    localparam logic [AW-1:0] A_LEN = A_LEN0 + AW'(c);
    localparam logic [AW-1:0] A_GO  = A_GO0 + AW'(c);
    logic [31:0]   mem [WORDS];
    logic [LW-1:0] lvl_q, len_q;
    wire           clr  = done && ch_q == 1'(c);
    wire [LW-1:0]  base = clr ? '0 : lvl_q;
    wire           push = wr_en && wr_addr == A_DATA && sel_q == 1'(c) && base <= ROOM;
    wire           go   = wr_en && wr_addr == A_GO && wr_data[0] && ctrl_q[1] && !busy_q;
    wire [LW-1:0]  fl   = (len_q < lvl_q) ? len_q : lvl_q;
    wire [31:0]    word = mem[idx_q[WW+1:2]];

    always_ff @(posedge clk) begin
      if (!rst_n || soft_rst) lvl_q <= '0;
      else lvl_q <= push ? base + LW'(4) : base;
      if (!rst_n || soft_rst) len_q <= '0;
      else if (wr_en && wr_addr == A_LEN) len_q <= len_in;
      else if (clr) len_q <= '0;
      if (push) mem[base[WW+1:2]] <= wr_data;
    end
  end

  assign lvl0 = g_ch[0].lvl_q;
  assign lvl1 = g_ch[1].lvl_q;
  assign len0 = g_ch[0].len_q;
  assign len1 = g_ch[1].len_q;
  assign word0 = g_ch[0].word;
  assign word1 = g_ch[1].word;
  assign go0 = g_ch[0].go;
  assign go1 = g_ch[1].go;
  assign fl0 = g_ch[0].fl;
  assign fl1 = g_ch[1].fl;

  assign cur_word = ch_q ? word1 : word0;
  assign tx_valid = busy_q;
  assign tx_data  = cur_word[8*idx_q[1:0] +: 8];
  assign tx_last  = busy_q && idx_q == flen_q - LW'(1);
  assign irq      = |(stat_q & mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_en && wr_addr == A_CTRL) ctrl_q <= {wr_data[31:1], 1'b0};

    if (!rst_n || soft_rst) begin
      mode_q <= '0;
      sel_q  <= 1'b0;
      mask_q <= '0;
      stat_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_MODE) mode_q <= wr_data;
      if (wr_addr == A_SEL)  sel_q  <= (wr_data < 32'd2) ? wr_data[0] : 1'b0;
      if (wr_addr == A_MASK) mask_q <= wr_data[1:0];
      stat_q <= (stat_q | (done ? (ch_q ? 2'b10 : 2'b01) : 2'b00))
                & ~((wr_addr == A_STAT) ? wr_data[1:0] : 2'b00);
    end else if (done) begin
      stat_q <= stat_q | (ch_q ? 2'b10 : 2'b01);
    end

    if (!rst_n || soft_rst) begin
      busy_q <= 1'b0;
      ch_q   <= 1'b0;
      idx_q  <= '0;
      flen_q <= '0;
    end else if (done) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      if (tx_ready) idx_q <= idx_q + LW'(1);
    end else if ((go0 && fl0 != '0) || (go1 && fl1 != '0)) begin
      busy_q <= 1'b1;
      ch_q   <= go1;
      idx_q  <= '0;
      flen_q <= go1 ? fl1 : fl0;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL:          rd_data = ctrl_q;
      A_MODE:          rd_data = mode_q;
      A_SEL:           rd_data = {31'b0, sel_q};
      A_LEN0:          rd_data = 32'(len0);
      A_LEN0 + AW'(1): rd_data = 32'(len1);
      A_MASK:          rd_data = {30'b0, mask_q};
      A_STAT:          rd_data = {30'b0, stat_q};
      default:         rd_data = '0;
    endcase
  end
endmodule

// File: rtl/txq_dual_chk.sv
module txq_dual_chk #(
  parameter int FIFO_BYTES = 2048,
  parameter int AW = 4
)(
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          wr_b0,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          tx_last,
  input logic          irq,
  input logic [1:0]    stat,
  input logic [$clog2(FIFO_BYTES+1)-1:0] lvl0,
  input logic [$clog2(FIFO_BYTES+1)-1:0] lvl1
);
  localparam int LW = $clog2(FIFO_BYTES + 1);
  localparam logic [AW-1:0] A_CTRL = AW'(0), A_STAT = AW'(9);
  wire sw_rst = wr_en && wr_addr == A_CTRL && wr_b0;

  // R8
  a_r8_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);
  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !sw_rst) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
  // R3
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl0 <= LW'(FIFO_BYTES)) && (lvl1 <= LW'(FIFO_BYTES)));
  a_r3_word_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl0 != $past(lvl0)) |-> (lvl0 == $past(lvl0) + LW'(4) || lvl0 == '0 || lvl0 == LW'(4)));
  // R7
  a_r7_status_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last && !sw_rst && !(wr_en && wr_addr == A_STAT)) |=> (stat != 2'b00));
  // R10
  a_r10_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat != 2'b00));
  // R11
  a_r11_soft_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (!tx_valid && !irq && lvl0 == '0 && lvl1 == '0));
endmodule

bind txq_dual txq_dual_chk #(.FIFO_BYTES(FIFO_BYTES), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_b0(wr_data[0]),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
  .irq(irq), .stat(stat_q), .lvl0(lvl0), .lvl1(lvl1));

// File: tb/txq_dual_bench.sv
`timescale 1ns/1ps
module txq_dual_bench;
  localparam int FB = 2048;
  logic clk = 0, rst_n = 0, wr_en = 0, tx_ready = 0;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic tx_valid, tx_last, irq;
  logic [7:0] tx_data;

  txq_dual u_txq_dual (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last), .irq(irq));

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, rdy_mode = 1;
  logic [15:0] lfsr = 16'hACE1;

  // reference model
  logic [7:0] m_q [2][$];
  logic [7:0] m_frame [$];
  logic [31:0] m_ctrl, m_mode;
  int m_len [2];
  logic [1:0] m_mask, m_stat;
  bit m_sel, m_busy, m_ch, wb;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_mode = 0; m_mask = 0; m_stat = 0; m_sel = 0; m_busy = 0; m_ch = 0;
      m_q[0].delete(); m_q[1].delete(); m_frame.delete(); m_len[0] = 0; m_len[1] = 0;
    end else begin
      wb = m_busy;
      if (m_busy && tx_ready) begin
        void'(m_frame.pop_front());
        if (m_frame.size() == 0) begin
          m_q[m_ch].delete(); m_len[m_ch] = 0; m_stat[m_ch] = 1'b1; m_busy = 0;
        end
      end
      if (wr_en) begin
        case (wr_addr)
          4'd0: begin
            if (wr_data[0]) begin
              m_mode = 0; m_mask = 0; m_stat = 0; m_sel = 0; m_busy = 0;
              m_q[0].delete(); m_q[1].delete(); m_frame.delete(); m_len[0] = 0; m_len[1] = 0;
            end
            m_ctrl = wr_data & ~32'd1;
          end
          4'd1: m_mode = wr_data;
          4'd2: m_sel = (wr_data < 2) ? wr_data[0] : 1'b0;
          4'd3: if (m_q[m_sel].size() <= FB - 4)
                  for (int k = 0; k < 4; k++) m_q[m_sel].push_back(wr_data[8*k +: 8]);
          4'd4, 4'd5: m_len[wr_addr - 4] = (wr_data > FB) ? FB : int'(wr_data);
          4'd6, 4'd7: if (wr_data[0] && m_ctrl[1] && !wb) begin
            int c, n;
            c = wr_addr - 6;
            n = (m_len[c] < m_q[c].size()) ? m_len[c] : m_q[c].size();
            if (n > 0) begin
              m_busy = 1; m_ch = c[0]; m_frame.delete();
              for (int i = 0; i < n; i++) m_frame.push_back(m_q[c][i]);
            end
          end
          4'd8: m_mask = wr_data[1:0];
          4'd9: m_stat = m_stat & ~wr_data[1:0];
          default: ;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check(tx_valid == m_busy, "R8 tx_valid", 32'(tx_valid), 32'(m_busy));
      if (m_busy) begin
        check(tx_data == m_frame[0], "R6 R8 tx_data", 32'(tx_data), 32'(m_frame[0]));
        check(tx_last == (m_frame.size() == 1), "R8 tx_last", 32'(tx_last), 32'(m_frame.size() == 1));
      end
      check(irq == |(m_stat & m_mask), "R10 irq", 32'(irq), 32'(|(m_stat & m_mask)));
    end
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_ready <= (rdy_mode == 1) ? 1'b1 : (rdy_mode == 0) ? 1'b0 : lfsr[3];
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string what);
    @(negedge clk); rd_addr = a; #1;
    check(rd_data == exp, what, rd_data, exp);
  endtask

  task automatic drain();
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic push(input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++)
      wr(4'd3, {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)} ^ {4{seed}});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(4'd0, 0, "R1 ctrl"); rd(4'd1, 0, "R1 mode"); rd(4'd2, 0, "R1 sel");
    rd(4'd4, 0, "R1 len0"); rd(4'd8, 0, "R1 mask"); rd(4'd9, 0, "R1 status");
    check(!tx_valid && !irq, "R1 outputs idle", {tx_valid, irq}, 0);
    wr(4'd0, 32'h2); rd(4'd0, 32'h2, "R5 ctrl enable stored");
    wr(4'd1, 32'hCAFE0055); rd(4'd1, 32'hCAFE0055, "R11 mode stored");
    // R2 select
    wr(4'd2, 1); rd(4'd2, 1, "R2 sel 1");
    wr(4'd2, 5); rd(4'd2, 0, "R2 sel out of range");
    wr(4'd2, 1); wr(4'd2, 2); rd(4'd2, 0, "R2 sel 2");
    // channel 0 frame of 10 bytes, ready always high
    push(3, 8'h10); wr(4'd4, 10); wr(4'd6, 1); drain();
    rd(4'd9, 1, "R7 status ch0"); rd(4'd4, 0, "R7 len0 cleared");
    check(!irq, "R10 masked irq low", 32'(irq), 0);
    wr(4'd8, 1); check(irq, "R10 irq on mask", 32'(irq), 1);
    wr(4'd9, 1); check(!irq, "R10 w1c clears", 32'(irq), 0); rd(4'd9, 0, "R10 status cleared");
    // channel 1 with random backpressure, length clamped to contents
    rdy_mode = 2;
    wr(4'd2, 1); push(2, 8'h5A); wr(4'd5, 100); wr(4'd7, 1); drain();
    rd(4'd9, 2, "R7 status ch1"); rd(4'd5, 0, "R7 len1 cleared");
    wr(4'd9, 3);
    // R4 clamp
    wr(4'd4, 5000); rd(4'd4, FB, "R4 clamp"); wr(4'd4, 2048); rd(4'd4, FB, "R4 exact");
    // R5 enable gating
    wr(4'd2, 0); push(1, 8'h33); wr(4'd4, 4);
    wr(4'd0, 0); wr(4'd6, 1); repeat (3) @(negedge clk);
    check(!tx_valid, "R5 start blocked by enable", 32'(tx_valid), 0);
    wr(4'd0, 2); wr(4'd6, 2); repeat (3) @(negedge clk);
    check(!tx_valid, "R5 start needs bit 0", 32'(tx_valid), 0);
    rd(4'd4, 4, "R5 length kept");
    // R6 zero length
    wr(4'd4, 0); wr(4'd6, 1); repeat (3) @(negedge clk);
    check(!tx_valid, "R6 zero length sends nothing", 32'(tx_valid), 0);
    rd(4'd9, 0, "R6 zero length no status");
    // R9 start while busy: stalled channel 0 frame, then start channel 1
    rdy_mode = 0;
    push(2, 8'h77); wr(4'd4, 7); wr(4'd6, 1);
    wr(4'd2, 1); push(1, 8'hA5); wr(4'd5, 4); wr(4'd7, 1);
    rdy_mode = 2; drain();
    rd(4'd9, 1, "R9 ignored start leaves ch1 status"); rd(4'd5, 4, "R9 ch1 length kept");
    wr(4'd7, 1); drain(); rd(4'd9, 3, "R9 ch1 later sends");
    wr(4'd9, 3);
    // R3 overflow: 514 words into channel 0, two dropped
    rdy_mode = 1;
    wr(4'd2, 0); push(514, 8'hC3); wr(4'd4, 4096); wr(4'd6, 1); drain();
    rd(4'd4, 0, "R3 full frame sent");
    // R11 soft reset mid-frame
    wr(4'd8, 3); rdy_mode = 0; push(4, 8'h21); wr(4'd4, 16); wr(4'd6, 1);
    check(tx_valid, "R11 frame in flight", 32'(tx_valid), 1);
    wr(4'd0, 32'h3);
    check(!tx_valid, "R11 frame aborted", 32'(tx_valid), 0);
    rd(4'd0, 2, "R11 reset bit not stored"); rd(4'd1, 0, "R11 mode cleared");
    rd(4'd8, 0, "R11 mask cleared"); rd(4'd9, 0, "R11 status cleared");
    rd(4'd4, 0, "R11 length cleared");
    rdy_mode = 1; wr(4'd4, 4); wr(4'd6, 1); repeat (3) @(negedge clk);
    check(!tx_valid, "R11 queue emptied", 32'(tx_valid), 0);
    // R1 hard reset
    wr(4'd1, 9); @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    rd(4'd1, 0, "R1 mode after reset"); rd(4'd0, 0, "R1 ctrl after reset");
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule